// File: doc/BRIEF.md
# Dual Line Prefetch Queue

This block is an instruction prefetch unit that sits between memory and a variable-length decoder. It holds two 16-byte line slots. It fetches aligned lines into whichever slot is empty, one request at a time, without waiting on the decoder, so both slots stay full whenever memory keeps up. The decoder sees a 3-byte window starting at the current stream position, with a valid bit per byte. Each cycle it returns a count of 0 to 3 bytes consumed.

The read position is a 5-bit pointer that wraps across the two slots, so the window may straddle the end of one slot and the start of the other. Once the pointer leaves a slot, that slot is released and refilled with the next sequential line. A flush, for example from a taken branch, empties both slots. It then restarts fetching at the aligned line that holds the target, and the stream begins at the target byte. Every request carries an epoch bit that toggles on each flush, so a response that was already in flight when the flush happened is discarded.

Top module: `prefetch_queue`

## Requirements
- R1: After reset both slots are empty, `win_valid_o` is 0, and a request is raised for the line at `RESET_ADDR` with tag 0.
- R2: Every request address has its low 4 bits at zero. An ungranted request holds its address and tag until granted. After a grant no new request is raised until the matching response arrives or a flush occurs.
- R3: A response fills the slot that issued the request, with line byte k taken from `mem_rdata_i[8k+7:8k]`. The two slots fill alternately with consecutive line addresses.
- R4: Window byte i is presented on `win_data_o[8i+7:8i]` and is the stream byte at pointer+i. Its bit `win_valid_o[i]` is 1 only if the slot holding that byte is filled, and the valid bits always form a prefix starting at bit 0.
- R5: The window crosses from one slot into the other, including the wrap from the last byte of slot 1 to byte 0 of slot 0.
- R6: `consume_i` advances the pointer by that many bytes in the next cycle. A count of 0 leaves the window unchanged.
- R7: A count larger than the number of valid window bytes advances the pointer only by the number of valid bytes.
- R8: When the pointer leaves a slot, that slot is released in the same edge, and a request for the next sequential line is raised in the following cycle.
- R9: A flush empties both slots in the next cycle. The next request is for `flush_addr_i` with its low 4 bits cleared, and the stream resumes at `flush_addr_i`.
- R10: The request tag toggles on each flush. A response whose tag differs from the current tag is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard both slots and restart fetching |
| flush_addr_i | input | 32 | Byte address at which to restart |
| consume_i | input | 2 | Bytes taken from the window this cycle (0..3) |
| win_data_o | output | 24 | Window bytes, byte 0 in the low bits |
| win_valid_o | output | 3 | Per-byte valid for the window |
| mem_req_o | output | 1 | Line request |
| mem_addr_o | output | 32 | Aligned line address |
| mem_tag_o | output | 1 | Epoch tag sent with the request |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Response data valid |
| mem_rtag_i | input | 1 | Tag returned with the response |
| mem_rdata_i | input | 128 | Returned line, byte 0 in the low bits |

## Verification
A consume or a flush applied in one cycle shows in the window one edge later. A response shows one edge after it is presented. A slot release raises the refill request in the cycle right after the edge that moved the pointer. The bench drives and samples only on the falling clock edge, so each result is read at the first falling edge after the rising edge that produces it. The memory model answers a fixed three cycles after a grant and can limit how many grants it gives. This lets a check stop the queue with exactly one slot filled, or keep a stale response in flight across a second flush, and then compare the window with a byte function of the address.

// File: rtl/pq_pkg.sv
package pq_pkg;
  localparam int unsigned NUM_SLOTS = 2;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/pq_fetch.sv
module pq_fetch #(
  parameter int unsigned LINE_W     = 28,
  parameter int unsigned OFF_W      = 4,
  parameter logic [LINE_W-1:0] RESET_LINE = '0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    flush_i,
  input  logic [LINE_W-1:0]       flush_line_i,
  input  logic [pq_pkg::NUM_SLOTS-1:0] slot_valid_i,
  output logic                    mem_req_o,
  output logic [LINE_W+OFF_W-1:0] mem_addr_o,
  output logic                    mem_tag_o,
  input  logic                    mem_gnt_i,
  input  logic                    mem_rvalid_i,
  input  logic                    mem_rtag_i,
  output logic                    wr_en_o,
  output logic                    wr_slot_o
);
  logic [LINE_W-1:0] line_q;
  logic              slot_q, epoch_q, pend_q;
  logic              accept;

  assign mem_req_o  = !pend_q && !slot_valid_i[slot_q];
  assign mem_addr_o = {line_q, {OFF_W{1'b0}}};
  assign mem_tag_o  = epoch_q;
  // stale epochs never match
  assign accept     = mem_rvalid_i && pend_q && (mem_rtag_i == epoch_q);
  assign wr_en_o    = accept && !flush_i;
  assign wr_slot_o  = slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= RESET_LINE;
      slot_q  <= 1'b0;
      epoch_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (flush_i) begin
      line_q  <= flush_line_i;
      slot_q  <= 1'b0;
      epoch_q <= ~epoch_q;
      pend_q  <= 1'b0;
    end else if (accept) begin
      pend_q  <= 1'b0;
      slot_q  <= ~slot_q;
      line_q  <= line_q + 1'b1;
    end else if (mem_req_o && mem_gnt_i) begin
      pend_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/pq_line_store.sv
module pq_line_store #(
  parameter int unsigned LINE_BYTES = 16,
  parameter int unsigned WIN_BYTES  = 3,
  localparam int unsigned OFF_W = $clog2(LINE_BYTES),
  localparam int unsigned PTR_W = OFF_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    flush_i,
  input  logic                    wr_en_i,
  input  logic                    wr_slot_i,
  input  logic [LINE_BYTES*8-1:0] wr_data_i,
  input  logic                    clr_en_i,
  input  logic                    clr_slot_i,
  input  logic [PTR_W-1:0]        rd_ptr_i,
  output logic [pq_pkg::NUM_SLOTS-1:0] slot_valid_o,
  output logic [WIN_BYTES*8-1:0]  win_data_o,
  output logic [WIN_BYTES-1:0]    win_valid_o
);
  logic [LINE_BYTES*8-1:0] lines [pq_pkg::NUM_SLOTS];

  for (genvar s = 0; s < pq_pkg::NUM_SLOTS; s++) begin : g_slot
    logic                    vld_q;
    logic [LINE_BYTES*8-1:0] data_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
      end else if (flush_i) begin
        vld_q <= 1'b0;
      end else if (wr_en_i && (wr_slot_i == 1'(s))) begin
        vld_q <= 1'b1;
      end else if (clr_en_i && (clr_slot_i == 1'(s))) begin
        vld_q <= 1'b0;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q <= '0;
      end else if (wr_en_i && (wr_slot_i == 1'(s))) begin
        data_q <= wr_data_i;
      end
    end

    assign slot_valid_o[s] = vld_q;
    assign lines[s]        = data_q;
  end

  for (genvar i = 0; i < WIN_BYTES; i++) begin : g_win
    logic [PTR_W-1:0] pos;
    assign pos = rd_ptr_i + PTR_W'(i);  // wraps across both slots
    assign win_data_o[8*i +: 8] = lines[pos[PTR_W-1]][8*pos[OFF_W-1:0] +: 8];
    assign win_valid_o[i]       = slot_valid_o[pos[PTR_W-1]];
  end
endmodule

// File: rtl/pq_read_ptr.sv
module pq_read_ptr #(
  parameter int unsigned OFF_W     = 4,
  parameter int unsigned WIN_BYTES = 3,
  parameter logic [OFF_W-1:0] RESET_OFF = '0,
  localparam int unsigned PTR_W = OFF_W + 1,
  localparam int unsigned CNT_W = $clog2(WIN_BYTES + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 flush_i,
  input  logic [OFF_W-1:0]     flush_off_i,
  input  logic [CNT_W-1:0]     consume_i,
  input  logic [WIN_BYTES-1:0] win_valid_i,
  output logic [PTR_W-1:0]     rd_ptr_o,
  output logic                 clr_en_o,
  output logic                 clr_slot_o
);
  logic [PTR_W-1:0] ptr_q, ptr_nxt;
  logic [CNT_W-1:0] avail, step;

  always_comb begin
    avail = '0;
    for (int i = 0; i < WIN_BYTES; i++) avail = avail + CNT_W'(win_valid_i[i]);
  end

  // never step past bytes that are not there
  assign step       = (consume_i > avail) ? avail : consume_i;
  assign ptr_nxt    = ptr_q + PTR_W'(step);
  assign clr_en_o   = !flush_i && (ptr_nxt[PTR_W-1] != ptr_q[PTR_W-1]);
  assign clr_slot_o = ptr_q[PTR_W-1];
  assign rd_ptr_o   = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= {1'b0, RESET_OFF};
    else if (flush_i) ptr_q <= {1'b0, flush_off_i};
    else              ptr_q <= ptr_nxt;
  end
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 16,
  parameter int unsigned WIN_BYTES  = 3,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES),
  localparam int unsigned PTR_W  = OFF_W + 1,
  localparam int unsigned LINE_W = ADDR_W - OFF_W,
  localparam int unsigned CNT_W  = $clog2(WIN_BYTES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    flush_i,
  input  logic [ADDR_W-1:0]       flush_addr_i,
  input  logic [CNT_W-1:0]        consume_i,
  output logic [WIN_BYTES*8-1:0]  win_data_o,
  output logic [WIN_BYTES-1:0]    win_valid_o,
  output logic                    mem_req_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic                    mem_tag_o,
  input  logic                    mem_gnt_i,
  input  logic                    mem_rvalid_i,
  input  logic                    mem_rtag_i,
  input  logic [LINE_BYTES*8-1:0] mem_rdata_i
);
  logic [pq_pkg::NUM_SLOTS-1:0] slot_valid;
  logic                         wr_en, wr_slot, clr_en, clr_slot;
  logic [PTR_W-1:0]             rd_ptr;

  pq_fetch #(
    .LINE_W(LINE_W), .OFF_W(OFF_W), .RESET_LINE(RESET_ADDR[ADDR_W-1:OFF_W])
  ) u_fetch (
    .clk_i, .rst_ni, .flush_i,
    .flush_line_i (flush_addr_i[ADDR_W-1:OFF_W]),
    .slot_valid_i (slot_valid),
    .mem_req_o, .mem_addr_o, .mem_tag_o, .mem_gnt_i, .mem_rvalid_i, .mem_rtag_i,
    .wr_en_o      (wr_en),
    .wr_slot_o    (wr_slot)
  );

  pq_line_store #(
    .LINE_BYTES(LINE_BYTES), .WIN_BYTES(WIN_BYTES)
  ) u_store (
    .clk_i, .rst_ni, .flush_i,
    .wr_en_i      (wr_en),
    .wr_slot_i    (wr_slot),
    .wr_data_i    (mem_rdata_i),
    .clr_en_i     (clr_en),
    .clr_slot_i   (clr_slot),
    .rd_ptr_i     (rd_ptr),
    .slot_valid_o (slot_valid),
    .win_data_o, .win_valid_o
  );

  pq_read_ptr #(
    .OFF_W(OFF_W), .WIN_BYTES(WIN_BYTES), .RESET_OFF(RESET_ADDR[OFF_W-1:0])
  ) u_ptr (
    .clk_i, .rst_ni, .flush_i,
    .flush_off_i  (flush_addr_i[OFF_W-1:0]),
    .consume_i,
    .win_valid_i  (win_valid_o),
    .rd_ptr_o     (rd_ptr),
    .clr_en_o     (clr_en),
    .clr_slot_o   (clr_slot)
  );
endmodule

// File: rtl/pq_checker.sv
module pq_checker #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned OFF_W     = 4,
  parameter int unsigned WIN_BYTES = 3,
  parameter int unsigned CNT_W     = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   flush_i,
  input logic [CNT_W-1:0]       consume_i,
  input logic [WIN_BYTES*8-1:0] win_data_o,
  input logic [WIN_BYTES-1:0]   win_valid_o,
  input logic                   mem_req_o,
  input logic [ADDR_W-1:0]      mem_addr_o,
  input logic                   mem_tag_o,
  input logic                   mem_gnt_i
);
  a_r2_req_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[OFF_W-1:0] == '0));

  a_r2_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i && !flush_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_tag_o)));

  a_r2_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_gnt_i && !flush_i) |=> !mem_req_o);

  a_r4_valid_prefix: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((win_valid_o + 1'b1) & win_valid_o) == '0);

  a_r6_hold_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consume_i == '0 && !flush_i && win_valid_o[0]) |=>
      (win_valid_o[0] && $stable(win_data_o[7:0])));

  a_r9_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (win_valid_o == '0));

  a_r10_epoch_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (mem_tag_o != $past(mem_tag_o)));
endmodule

bind prefetch_queue pq_checker #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .WIN_BYTES(WIN_BYTES), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i), .consume_i(consume_i),
  .win_data_o(win_data_o), .win_valid_o(win_valid_o), .mem_req_o(mem_req_o),
  .mem_addr_o(mem_addr_o), .mem_tag_o(mem_tag_o), .mem_gnt_i(mem_gnt_i)
);

// File: tb/prefetch_queue_test.sv
`timescale 1ns/1ps
module prefetch_queue_test;
  localparam int LAT = 3;
  localparam int NWALK = 24;
  localparam logic [1:0] WALK [NWALK] = '{
    2'd3, 2'd3, 2'd2, 2'd1, 2'd3, 2'd0, 2'd3, 2'd3, 2'd2, 2'd3, 2'd1, 2'd3,
    2'd3, 2'd0, 2'd2, 2'd3, 2'd3, 2'd1, 2'd3, 2'd2, 2'd3, 2'd3, 2'd2, 2'd3};

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         flush = 1'b0;
  logic [31:0]  flush_addr = '0;
  logic [1:0]   consume = '0;
  logic [23:0]  win_data;
  logic [2:0]   win_valid;
  logic         mem_req, mem_tag, mem_gnt, mem_rvalid, mem_rtag;
  logic [31:0]  mem_addr;
  logic [127:0] mem_rdata;

  int n_chk = 0, n_fail = 0;
  int budget = 0;  // grants left, -1 = unlimited
  bit done = 1'b0;

  always #10 clk = ~clk;

  prefetch_queue uut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .flush_addr_i(flush_addr),
    .consume_i(consume), .win_data_o(win_data), .win_valid_o(win_valid),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_tag_o(mem_tag),
    .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid), .mem_rtag_i(mem_rtag),
    .mem_rdata_i(mem_rdata));

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    logic [31:0] t;
    t = a * 32'd7 + (a >> 4) * 32'd13 + 32'd3;
    return t[7:0];
  endfunction

  function automatic logic [23:0] exp_win(input logic [31:0] a);
    return {mem_byte(a + 2), mem_byte(a + 1), mem_byte(a)};
  endfunction

  // memory model: fixed latency, up to 4 in flight
  logic        q_busy [4];
  logic [31:0] q_addr [4];
  logic        q_tag  [4];
  int          q_cnt  [4];
  initial begin
    mem_gnt = 0; mem_rvalid = 0; mem_rtag = 0; mem_rdata = '0;
    for (int k = 0; k < 4; k++) begin q_busy[k] = 0; q_cnt[k] = 0; q_addr[k] = '0; q_tag[k] = 0; end
    forever begin
      @(negedge clk);
      mem_rvalid = 0;
      for (int k = 0; k < 4; k++) begin
        if (q_busy[k]) begin
          q_cnt[k]--;
          if (q_cnt[k] == 0) begin
            mem_rvalid = 1; mem_rtag = q_tag[k];
            for (int b = 0; b < 16; b++) mem_rdata[8*b +: 8] = mem_byte(q_addr[k] + b);
            q_busy[k] = 0;
          end
        end
      end
      mem_gnt = 0;
      if (rst_n && mem_req && budget != 0) begin
        for (int k = 0; k < 4; k++) begin
          if (!mem_gnt && !q_busy[k]) begin
            mem_gnt = 1; q_busy[k] = 1; q_cnt[k] = LAT;
            q_addr[k] = mem_addr; q_tag[k] = mem_tag;
          end
        end
        if (budget > 0) budget--;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_full();
    int n = 0;
    while (win_valid != 3'b111 && n < 100) begin @(negedge clk); n++; end
  endtask

  task automatic do_flush(input logic [31:0] a);
    flush = 1; flush_addr = a;
    @(negedge clk);
    flush = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] exp;
    logic [23:0] held;
    logic        tag0;
    step(2);
    rst_n = 1;
    @(negedge clk);
    chk(mem_req == 1'b1, "R1 req after reset", {31'd0, mem_req}, 32'd1);
    chk(mem_addr == 32'd0 && mem_tag == 1'b0, "R1 reset addr/tag", mem_addr, 32'd0);
    chk(win_valid == 3'b000, "R1 window empty", {29'd0, win_valid}, 32'd0);

    // sequential walk across slot boundaries and refills
    budget = -1;
    exp = 32'd0;
    for (int i = 0; i < NWALK; i++) begin
      string tg;
      wait_full();
      tg = (exp % 16 > 13) ? "R5 window span" : (exp >= 32 ? "R8 refilled window" : "R4 window bytes");
      chk(win_valid == 3'b111 && win_data == exp_win(exp), tg, {8'd0, win_data}, {8'd0, exp_win(exp)});
      consume = WALK[i];
      exp += 32'(WALK[i]);
      @(negedge clk);
      consume = 0;
    end

    // R6: zero consume holds the window
    wait_full();
    held = win_data;
    step(3);
    chk(win_valid == 3'b111 && win_data == held, "R6 zero consume", {8'd0, win_data}, {8'd0, held});
    chk(win_data == exp_win(exp), "R6 position kept", {8'd0, win_data}, {8'd0, exp_win(exp)});

    // R9/R10/R2: flush to unaligned target, no grants
    step(10);
    budget = 0;
    tag0 = mem_tag;
    do_flush(32'h0000_0107);
    chk(win_valid == 3'b000, "R9 flush empties", {29'd0, win_valid}, 32'd0);
    chk(mem_req && mem_addr == 32'h100, "R9 aligned restart", mem_addr, 32'h100);
    chk(mem_tag == ~tag0, "R10 tag toggles", {31'd0, mem_tag}, {31'd0, ~tag0});
    step(2);
    chk(mem_req && mem_addr == 32'h100, "R2 request held", mem_addr, 32'h100);
    budget = -1;
    wait_full();
    chk(win_data == exp_win(32'h107), "R9 skip to target", {8'd0, win_data}, {8'd0, exp_win(32'h107)});

    // R5/R7: one slot filled, window partly valid, overshoot clamped
    step(10);
    budget = 1;
    do_flush(32'h0000_020E);
    begin
      int n = 0;
      while (win_valid == 3'b000 && n < 50) begin @(negedge clk); n++; end
    end
    step(2);
    chk(win_valid == 3'b011, "R4 valid only in filled slot", {29'd0, win_valid}, 32'd3);
    chk(win_data[15:0] == exp_win(32'h20E)[15:0], "R5 tail bytes", {16'd0, win_data[15:0]}, {16'd0, exp_win(32'h20E)[15:0]});
    consume = 3;
    @(negedge clk);
    consume = 0;
    chk(win_valid == 3'b000, "R7 clamped to valid", {29'd0, win_valid}, 32'd0);
    chk(mem_req && mem_addr == 32'h210, "R3 next line request", mem_addr, 32'h210);
    budget = -1;
    wait_full();
    chk(win_data == exp_win(32'h210), "R7 advanced by two", {8'd0, win_data}, {8'd0, exp_win(32'h210)});

    // R8/R3: release triggers next-line request
    step(10);
    budget = 2;
    do_flush(32'h0000_0300);
    wait_full();
    step(LAT + 4);
    chk(!mem_req, "R8 no request while full", {31'd0, mem_req}, 32'd0);
    for (int i = 0; i < 5; i++) begin consume = 3; @(negedge clk); end
    consume = 0;
    chk(!mem_req, "R8 slot still in use", {31'd0, mem_req}, 32'd0);
    consume = 1;
    @(negedge clk);
    consume = 0;
    chk(mem_req && mem_addr == 32'h320, "R8 refill request", mem_addr, 32'h320);
    chk(win_valid == 3'b111 && win_data == exp_win(32'h310), "R3 second slot bytes", {8'd0, win_data}, {8'd0, exp_win(32'h310)});

    // R10: response in flight across a second flush is dropped
    budget = -1;
    step(10);
    do_flush(32'h0000_0400);
    @(negedge clk);
    do_flush(32'h0000_0500);
    step(2);
    chk(win_valid == 3'b000, "R10 stale response dropped", {29'd0, win_valid}, 32'd0);
    wait_full();
    chk(win_data == exp_win(32'h500), "R10 new target bytes", {8'd0, win_data}, {8'd0, exp_win(32'h500)});

    finish_run();
  end
endmodule